// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block is a single performance-monitor counter. Software loads an 8-bit event code that picks one hardware occurrence to count. Every cycle a retiring pipeline presents a vector of per-event strobes. It also presents one flag that tells whether the retired instruction was unconditional or passed its condition test. The block decides whether the selected event counts in that cycle and, while enabled, advances a counter.

Each event code carries its own rule. Data reads, data writes and exception returns count only when the condition flag is set. Retired instructions and immediate branches count whether or not the condition passed. Exceptions taken, misprediction flushes and memory-system events count on the bare strobe. The cycle event counts every enabled clock. Reserved and unassigned codes never count.

When the counter wraps to zero it raises a sticky overflow flag, which software clears with a write of one. Register access is a plain single-cycle port. A write is taken at the clock edge where `reg_wr_en` is high, and read data is a combinational function of `reg_addr`. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `evsel_perf_counter`

## Requirements
- R1: After reset the event select, enable, counter and overflow flag all read as zero.
- R2: Codes 0x06 (strobe bit 0, data read), 0x07 (bit 1, data write) and 0x0A (bit 4, exception return) increment only when their strobe and `ev_cond_pass` are both 1.
- R3: Codes 0x08 (strobe bit 2, instruction retired) and 0x0D (bit 5, immediate branch) increment on their strobe whatever the value of `ev_cond_pass`.
- R4: Codes 0x09 (bit 3, exception taken), 0x10 (bit 6, misprediction flush), 0x40 (bit 7), 0x41 (bit 8), 0x42 (bit 9) and 0x43 (bit 10) increment on their strobe alone.
- R5: Code 0x11 increments the counter on every enabled clock cycle.
- R6: Reserved codes 0x13 to 0x3F and every other code not listed in R2 to R5 never change the counter.
- R7: The counter changes only while the enable bit (address 1, bit 0) is 1, and it advances by at most one per cycle.
- R8: Writing 1 to address 1, bit 1 zeroes the counter at that edge, overriding any increment in the same cycle. The bit itself reads back as 0.
- R9: A wrap from all-ones to zero sets the overflow flag (address 3, bit 0). The flag stays set until a write of 1 to that bit. A set and a clear in the same cycle leave the flag set.
- R10: A new event select takes effect from the cycle after its write, and the write leaves the count unchanged.
- R11: Register map: address 0 holds the event select in bits 7:0, address 1 the control bits, address 2 the read-only count (zero-extended), and address 3 the overflow status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_strobe | input | 11 | Per-event strobes from the retiring pipeline |
| ev_cond_pass | input | 1 | Instruction was unconditional or passed its condition |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
A wrong qualification rule or a stale event select shows up as a wrong count at address 2 one cycle after the offending strobe. The bench reads the count after every cycle, so the error is caught at that first cycle. A missed or early wrap shows up as a flag at address 3 that disagrees with the model on the next status read. Random stimulus drives the counter through many wraps to expose this. A reset that loses to an increment, or a clear that beats a set, leaves a count of 1 or a cleared flag, and this is visible in the cycle right after the write.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int EVW  = 8;
  localparam int NSTB = 11;
  localparam int IDXW = $clog2(NSTB);

  localparam logic [1:0] ADDR_SEL   = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_COUNT = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;

  // strobes gated by the condition-pass flag: data read, data write, exception return
  localparam logic [NSTB-1:0] COND_MASK = NSTB'(11'b000_0001_0011);

  typedef enum logic [1:0] {RULE_NONE, RULE_STROBE, RULE_CYCLE} rule_e;

  typedef struct packed {
    rule_e           rule;
    logic [IDXW-1:0] idx;
  } ev_map_t;

  function automatic ev_map_t decode_event(input logic [EVW-1:0] code);
    ev_map_t m;
    m.rule = RULE_STROBE;
    m.idx  = '0;
    case (code)
      8'h06: m.idx = IDXW'(0);
      8'h07: m.idx = IDXW'(1);
      8'h08: m.idx = IDXW'(2);
      8'h09: m.idx = IDXW'(3);
      8'h0A: m.idx = IDXW'(4);
      8'h0D: m.idx = IDXW'(5);
      8'h10: m.idx = IDXW'(6);
      8'h11: m.rule = RULE_CYCLE;
      8'h40: m.idx = IDXW'(7);
      8'h41: m.idx = IDXW'(8);
      8'h42: m.idx = IDXW'(9);
      8'h43: m.idx = IDXW'(10);
      default: m.rule = RULE_NONE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pmc_event_qual.sv
module pmc_event_qual
  import pmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EVW-1:0]  sel,
  input  logic [NSTB-1:0] stb,
  input  logic            cond_pass,
  input  logic            en,
  output logic            inc
);
  logic [NSTB-1:0] qual;
  ev_map_t         map;
  logic            hit;

  for (genvar i = 0; i < NSTB; i++) begin : g_qual
    if (COND_MASK[i]) begin : g_gated
      assign qual[i] = stb[i] & cond_pass;
    end else begin : g_raw
      assign qual[i] = stb[i];
    end
  end

  always_comb begin
    map = decode_event(sel);
    case (map.rule)
      RULE_STROBE: hit = qual[map.idx];
      RULE_CYCLE:  hit = 1'b1;
      default:     hit = 1'b0;
    endcase
  end

  assign inc = en & hit;

  // R6: reserved window never produces an increment
  a_r6_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= 8'h13 && sel <= 8'h3F) |-> !inc);
  // R7: no increment while disabled
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !inc);
  // R2: condition-gated codes stay quiet on a failed condition
  a_r2_cond_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel == 8'h06 || sel == 8'h07 || sel == 8'h0A) && !cond_pass) |-> !inc);
endmodule

// File: rtl/pmc_count.sv
module pmc_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             swrst,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (swrst)  count <= '0;
    else if (inc)    count <= count + 1'b1;
  end

  assign wrap = inc & ~swrst & (count == CNT_MAX);

  // R8: software reset wins
  a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (count == '0));
  // R7: idle cycles hold the count
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !swrst) |=> $stable(count));
  // R7: at most one step per cycle
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1) || count == '0));
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             ovf_set,
  output logic [EVW-1:0]   sel,
  output logic             en,
  output logic             swrst,
  output logic [31:0]      rdata
);
  logic ovf;
  logic wr_sel, wr_ctrl, ovf_clr;
  logic unused_wdata;

  assign wr_sel  = wr_en && addr == ADDR_SEL;
  assign wr_ctrl = wr_en && addr == ADDR_CTRL;
  assign ovf_clr = wr_en && addr == ADDR_STAT && wdata[0];
  assign swrst   = wr_ctrl && wdata[1];
  assign unused_wdata = ^wdata[31:EVW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      en  <= 1'b0;
      ovf <= 1'b0;
    end else begin
      if (wr_sel)  sel <= wdata[EVW-1:0];
      if (wr_ctrl) en  <= wdata[0];
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_SEL:   rdata[EVW-1:0]   = sel;
      ADDR_CTRL:  rdata[0]         = en;
      ADDR_COUNT: rdata[CNT_W-1:0] = count;
      default:    rdata[0]         = ovf;
    endcase
  end

  // R9: flag is sticky without a clear
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);
  // R9: a wrap always leaves the flag set
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf);
  // R10: select only moves on its own write
  a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel));
endmodule

// File: rtl/evsel_perf_counter.sv
module evsel_perf_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTB-1:0] ev_strobe,
  input  logic            ev_cond_pass,
  input  logic            reg_wr_en,
  input  logic [1:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata
);
  logic [EVW-1:0]   sel;
  logic             en, swrst, inc, wrap;
  logic [CNT_W-1:0] count;

  pmc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .count(count), .ovf_set(wrap),
    .sel(sel), .en(en), .swrst(swrst), .rdata(reg_rdata)
  );

  pmc_event_qual u_qual (
    .clk(clk), .rst_n(rst_n), .sel(sel), .stb(ev_strobe),
    .cond_pass(ev_cond_pass), .en(en), .inc(inc)
  );

  pmc_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(inc), .swrst(swrst),
    .count(count), .wrap(wrap)
  );
endmodule

// File: tb/evsel_perf_counter_bench.sv
module evsel_perf_counter_bench;
  import pmc_pkg::*;
  localparam int CW = 10;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NSTB-1:0] stb = '0;
  logic cp = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;

  evsel_perf_counter #(.CNT_W(CW)) u_evsel_perf_counter (
    .clk(clk), .rst_n(rst_n), .ev_strobe(stb), .ev_cond_pass(cp),
    .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_sel = '0;
  logic m_en = 0, m_ovf = 0;
  logic [CW-1:0] m_cnt = '0;

  function automatic bit exp_inc(logic [7:0] s, logic [NSTB-1:0] e, logic c, logic enb);
    if (!enb) return 0;
    case (s)
      8'h06: return e[0] & c;
      8'h07: return e[1] & c;
      8'h08: return e[2];
      8'h09: return e[3];
      8'h0A: return e[4] & c;
      8'h0D: return e[5];
      8'h10: return e[6];
      8'h11: return 1;
      8'h40: return e[7];
      8'h41: return e[8];
      8'h42: return e[9];
      8'h43: return e[10];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] s);
    case (s)
      8'h06, 8'h07, 8'h0A: return "R2";
      8'h08, 8'h0D: return "R3";
      8'h09, 8'h10, 8'h40, 8'h41, 8'h42, 8'h43: return "R4";
      8'h11: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [31:0] exp_reg(logic [1:0] a);
    case (a)
      2'd0: return {24'd0, m_sel};
      2'd1: return {31'd0, m_en};
      2'd2: return {{(32-CW){1'b0}}, m_cnt};
      default: return {31'd0, m_ovf};
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [1:0] a);
    addr = a;
    #1;
    check(tag, rdata, exp_reg(a));
  endtask

  task automatic cyc(logic [NSTB-1:0] s, logic c, logic w, logic [1:0] a, logic [31:0] d);
    bit inc, setf, clr, rq;
    stb = s; cp = c; wr = w; addr = a; wdata = d;
    @(posedge clk);
    inc = exp_inc(m_sel, s, c, m_en);
    rq  = w && a == 2'd1 && d[1];
    clr = w && a == 2'd3 && d[0];
    setf = 0;
    if (rq) m_cnt = '0;
    else if (inc) begin
      if (m_cnt == CMAX) setf = 1;
      m_cnt = m_cnt + 1'b1;
    end
    if (setf) m_ovf = 1;
    else if (clr) m_ovf = 0;
    if (w && a == 2'd0) m_sel = d[7:0];
    if (w && a == 2'd1) m_en = d[0];
    #1;
    stb = '0; cp = 0; wr = 0; wdata = '0;
  endtask

  task automatic idle(int n, logic [NSTB-1:0] s, logic c);
    for (int i = 0; i < n; i++) cyc(s, c, 0, 2'd0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  logic [7:0] sel_list [18] = '{8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0D, 8'h0E,
                                8'h10, 8'h11, 8'h12, 8'h20, 8'h3F, 8'h40, 8'h41, 8'h42,
                                8'h43, 8'hFF};

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    for (int a = 0; a < 4; a++) rd("R1", 2'(a));

    cyc('0, 0, 1, 2'd0, 32'h06);
    cyc('0, 0, 1, 2'd1, 32'h1);
    rd("R11", 2'd0); rd("R11", 2'd1);
    cyc(NSTB'(1), 0, 0, 2'd0, 0); rd("R2", 2'd2);   // failed condition: stays 0
    cyc(NSTB'(1), 1, 0, 2'd0, 0); rd("R2", 2'd2);   // passes: 1
    cyc(NSTB'(4), 0, 1, 2'd0, 32'h08); rd("R10", 2'd2); // old select still active
    cyc(NSTB'(4), 0, 0, 2'd0, 0); rd("R3", 2'd2);   // new select counts, count kept
    cyc(NSTB'(8), 0, 1, 2'd0, 32'h09);
    cyc(NSTB'(8), 0, 0, 2'd0, 0); rd("R4", 2'd2);
    cyc('0, 0, 1, 2'd0, 32'h20);
    idle(5, '1, 1); rd("R6", 2'd2);
    cyc('0, 0, 1, 2'd0, 32'h11);
    idle(3, '0, 0); rd("R5", 2'd2);
    cyc('0, 0, 1, 2'd1, 32'h0);
    idle(4, '1, 1); rd("R7", 2'd2);
    cyc('0, 0, 1, 2'd1, 32'h1); rd("R7", 2'd2);
    cyc('0, 0, 1, 2'd1, 32'h3); rd("R8", 2'd2); rd("R8", 2'd1);
    cyc('0, 0, 1, 2'd2, 32'h55); rd("R11", 2'd2);   // count is read-only
    idle(int'(CMAX) - 2, '0, 0); rd("R9", 2'd2); rd("R9", 2'd3);
    cyc('0, 0, 0, 2'd0, 0); rd("R9", 2'd2); rd("R9", 2'd3);
    idle(7, '0, 0); rd("R9", 2'd3);
    cyc('0, 0, 1, 2'd3, 32'h1); rd("R9", 2'd3);
    idle(int'(CMAX) - 8, '0, 0); rd("R9", 2'd2);
    cyc('0, 0, 1, 2'd3, 32'h1); rd("R9", 2'd3);     // set beats clear

    for (int i = 0; i < 4000; i++) begin
      logic [NSTB-1:0] s;
      logic c, w;
      logic [1:0] a;
      logic [31:0] d;
      string t;
      s = NSTB'($urandom);
      c = 1'($urandom);
      w = ($urandom % 16) == 0;
      a = 2'($urandom);
      case (a)
        2'd0: d = {24'd0, sel_list[$urandom % 18]};
        2'd1: d = {30'd0, 1'(($urandom % 4) == 0), 1'(($urandom % 4) != 0)};
        default: d = $urandom;
      endcase
      t = tag_of(m_sel);
      cyc(s, c, w, a, d);
      rd(t, 2'd2);
      if (i % 8 == 0) begin
        rd("R9", 2'd3);
        rd("R10", 2'd0);
      end
    end
    finish_run();
  end
endmodule